// File: doc/BRIEF.md
# Self-Test Character Pattern Engine

This block supplies the characters for a serial transmitter and can turn itself into a self-test pattern source. In normal operation a character register takes one character per clock. Each character is a command/data flag plus an 8-bit payload. The character comes from one of three places: the transmit queue output, a bypass input register, or a special code chosen by the transmit control logic. When the active-low test enable is pulled low, that same register becomes a 9-bit maximal-length shift register. It is seeded to all ones. It then runs through a fixed 511-character pseudo-random sequence that covers every data code, every special code and the violation code.

A checker in the same block regenerates the sequence on its own. It compares received characters against it and counts mismatches in a saturating counter. It locks onto the incoming stream when it sees the start character, which is the data character 0xFF produced by the all-ones state. The transmitter and receiver ends of a link can therefore each use one instance, and the receiver instance needs no shared timing with the transmitter. Line coding and serialization sit downstream and are not part of this block.

Top module: `bist_pattern_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, tx_cmd, tx_data, test_active, seq_start, err_count and chk_locked are all zero.
- R2: With bist_en_n high, the character register loads on every clock, and the loaded character appears on the outputs one cycle after the inputs are sampled. The source is chosen by src_sel: 0 takes {fifo_cmd, fifo_data}, 1 takes {byp_cmd, byp_data}, and 2 or 3 take a command character with payload ctl_code.
- R3: In the first cycle after bist_en_n is sampled low, the register holds the all-ones seed. The outputs then show the data character 0xFF (tx_cmd = 0), with test_active = 1 and seq_start = 1.
- R4: In test mode the state s advances each clock to {s[7:0], s[8] ^ s[4]}. It never reaches zero and repeats every 511 clocks.
- R5: seq_start is high for exactly one cycle in every 511, namely whenever the state equals the seed.
- R6: A state s with s[8] = 1 gives a data character whose payload is s[7:0] (tx_cmd = 0). A state with s[8] = 0 gives a command character (tx_cmd = 1). Its payload p = s[7:0] maps to p-1 when 1 ≤ p ≤ 16; any other p maps to the violation code 15.
- R7: Over one period the outputs show all 256 data payloads and all 16 command codes (0 to 15).
- R8: While locked in test mode, each received character (rx_valid = 1) that differs from the expected one adds 1 to err_count. The count stops at 0xFFFF.
- R9: Receiving the start character (rx_cmd = 0, rx_data = 0xFF) sets chk_locked. The expected sequence then continues from the state after the seed. Until lock, received characters add no errors.
- R10: When bist_en_n goes high, the register returns to normal loading on the next clock and test_active drops. Each new entry into test mode reseeds the register, clears err_count and drops chk_locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bist_en_n | input | 1 | Active-low self-test enable |
| src_sel | input | 2 | Normal-mode source: 0 queue, 1 bypass, 2/3 control |
| fifo_cmd | input | 1 | Command flag from the transmit queue |
| fifo_data | input | 8 | Payload from the transmit queue |
| byp_cmd | input | 1 | Command flag from the bypass register |
| byp_data | input | 8 | Payload from the bypass register |
| ctl_code | input | 8 | Special code from the control logic |
| tx_cmd | output | 1 | Outgoing command/data flag |
| tx_data | output | 8 | Outgoing payload |
| test_active | output | 1 | Register is running as the pattern generator |
| seq_start | output | 1 | One-cycle strobe on the seed state |
| rx_valid | input | 1 | Received character strobe for the checker |
| rx_cmd | input | 1 | Received command flag |
| rx_data | input | 8 | Received payload |
| err_count | output | 16 | Saturating mismatch count |
| chk_locked | output | 1 | Checker is aligned to the incoming sequence |

## Verification
The bench runs more than two full periods and compares every character against an arithmetic model. It would catch a wrong tap, a wrong mapping or a seed that is not all ones as soon as the first character differs. It also collects coverage of all 256 data and 16 command codes, so a mapping that loses code 0 or the violation code fails the coverage check. On the checker side, the bench sends garbage before lock, sends a start character in mid-stream while already locked, and forces more than 65,535 mismatches. These catch a checker that counts before alignment, one that fails to realign, and one whose counter wraps to zero. Leaving test mode and entering it again shows whether the register reseeds and whether the error count is cleared.

// File: rtl/bist_pkg.sv
package bist_pkg;
   typedef enum logic [1:0] {
      SRC_FIFO    = 2'd0,
      SRC_BYP     = 2'd1,
      SRC_CTL     = 2'd2,
      SRC_CTL_ALT = 2'd3
   } src_e;
endpackage

// File: rtl/bist_char_map.sv
module bist_char_map #(
   parameter int DATA_W      = 8,
   parameter int NUM_SPECIAL = 16
) (
   input  logic [DATA_W:0]   state,
   output logic              cmd,
   output logic [DATA_W-1:0] code
);
   localparam logic [DATA_W-1:0] NSPEC_V = DATA_W'(NUM_SPECIAL);
   localparam logic [DATA_W-1:0] VIOL    = DATA_W'(NUM_SPECIAL - 1);
   localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

   logic [DATA_W-1:0] payload;
   assign payload = state[DATA_W-1:0];

   always_comb begin
      if (state[DATA_W]) begin
         cmd  = 1'b0;
         code = payload;
      end else begin
         cmd = 1'b1;
         if (payload != '0 && payload <= NSPEC_V) code = payload - ONE;
         else                                     code = VIOL;
      end
   end
endmodule

// File: rtl/bist_lfsr_gen.sv
module bist_lfsr_gen
   import bist_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int TAP_HI = 8,
   parameter int TAP_LO = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_req,
   input  logic [1:0]        src_sel,
   input  logic              fifo_cmd,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              byp_cmd,
   input  logic [DATA_W-1:0] byp_data,
   input  logic [DATA_W-1:0] ctl_code,
   output logic [DATA_W:0]   state,
   output logic              mode_q
);
   localparam int              ST_W   = DATA_W + 1;
   localparam int              PERIOD = (1 << ST_W) - 1;
   localparam logic [ST_W-1:0] SEED   = '1;

   if (TAP_HI != ST_W - 1) begin : g_bad_tap_hi
      $error("TAP_HI must be the top state bit");
   end
   if (TAP_LO < 0 || TAP_LO >= TAP_HI) begin : g_bad_tap_lo
      $error("TAP_LO must lie below TAP_HI");
   end

   logic [ST_W-1:0] stepped;
   assign stepped = {state[ST_W-2:0], state[TAP_HI] ^ state[TAP_LO]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= '0;
         mode_q <= 1'b0;
      end else begin
         mode_q <= test_req;
         if (test_req) begin
            state <= mode_q ? stepped : SEED;
         end else begin
            case (src_e'(src_sel))
               SRC_FIFO: state <= {fifo_cmd, fifo_data};
               SRC_BYP:  state <= {byp_cmd, byp_data};
               default:  state <= {1'b1, ctl_code};
            endcase
         end
      end
   end

   // period watch used only by the assertion below
   logic [ST_W-1:0] per_cnt;
   logic            per_seen;
   always_ff @(posedge clk) begin
      if (!rst_n || !mode_q) begin
         per_cnt  <= '0;
         per_seen <= 1'b0;
      end else if (state == SEED) begin
         per_cnt  <= '0;
         per_seen <= 1'b1;
      end else begin
         per_cnt <= per_cnt + 1'b1;
      end
   end

   // R3
   seed_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_q) |-> state == SEED);
   // R4
   never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> state != '0);
   // R4
   period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && per_seen && state == SEED) |-> per_cnt == ST_W'(PERIOD - 1));
   // R2
   bypass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_req && src_sel == 2'd1) |=> state == {$past(byp_cmd), $past(byp_data)});
endmodule

// File: rtl/bist_checker.sv
module bist_checker #(
   parameter int DATA_W      = 8,
   parameter int NUM_SPECIAL = 16,
   parameter int ERR_W       = 16,
   parameter int TAP_HI      = 8,
   parameter int TAP_LO      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_req,
   input  logic              rx_valid,
   input  logic              rx_cmd,
   input  logic [DATA_W-1:0] rx_data,
   output logic [ERR_W-1:0]  err_count,
   output logic              locked
);
   localparam int               ST_W    = DATA_W + 1;
   localparam logic [ST_W-1:0]  SEED    = '1;
   localparam logic [ERR_W-1:0] ERR_MAX = '1;

   logic [ST_W-1:0]   exp_st;
   logic              mode_q;
   logic              exp_cmd;
   logic [DATA_W-1:0] exp_code;

   bist_char_map #(.DATA_W(DATA_W), .NUM_SPECIAL(NUM_SPECIAL)) u_map (
      .state(exp_st), .cmd(exp_cmd), .code(exp_code));

   function automatic logic [ST_W-1:0] adv(input logic [ST_W-1:0] s);
      return {s[ST_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
   endfunction

   logic is_start, mismatch;
   assign is_start = !rx_cmd && rx_data == '1;
   assign mismatch = {rx_cmd, rx_data} != {exp_cmd, exp_code};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_st    <= '0;
         mode_q    <= 1'b0;
         locked    <= 1'b0;
         err_count <= '0;
      end else begin
         mode_q <= test_req;
         if (!test_req) begin
            locked <= 1'b0;
         end else if (!mode_q) begin
            locked    <= 1'b0;
            err_count <= '0;
         end else if (rx_valid) begin
            if (is_start) begin
               exp_st <= adv(SEED);
               locked <= 1'b1;
            end else if (locked) begin
               exp_st <= adv(exp_st);
               if (mismatch && err_count != ERR_MAX) err_count <= err_count + 1'b1;
            end
         end
      end
   end

   // R8
   err_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && test_req) |=> err_count >= $past(err_count));
   // R8
   err_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && test_req && err_count == ERR_MAX) |=> err_count == ERR_MAX);
   // R9
   no_count_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && test_req && !locked) |=> $stable(err_count));
   // R10
   err_clear_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_req && !mode_q) |=> (err_count == '0 && !locked));
endmodule

// File: rtl/bist_pattern_engine.sv
module bist_pattern_engine #(
   parameter int DATA_W      = 8,
   parameter int NUM_SPECIAL = 16,
   parameter int ERR_W       = 16,
   parameter int TAP_HI      = 8,
   parameter int TAP_LO      = 4,
   parameter bit CHECKER_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bist_en_n,
   input  logic [1:0]        src_sel,
   input  logic              fifo_cmd,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              byp_cmd,
   input  logic [DATA_W-1:0] byp_data,
   input  logic [DATA_W-1:0] ctl_code,
   output logic              tx_cmd,
   output logic [DATA_W-1:0] tx_data,
   output logic              test_active,
   output logic              seq_start,
   input  logic              rx_valid,
   input  logic              rx_cmd,
   input  logic [DATA_W-1:0] rx_data,
   output logic [ERR_W-1:0]  err_count,
   output logic              chk_locked
);
   localparam int                ST_W = DATA_W + 1;
   localparam logic [DATA_W-1:0] VIOL = DATA_W'(NUM_SPECIAL - 1);

   if (NUM_SPECIAL < 2 || NUM_SPECIAL > (1 << DATA_W) - 1) begin : g_bad_nspec
      $error("NUM_SPECIAL out of range for DATA_W");
   end
   if (ERR_W < 1) begin : g_bad_errw
      $error("ERR_W must be positive");
   end

   logic              test_req, mode_q, map_cmd;
   logic [ST_W-1:0]   state;
   logic [DATA_W-1:0] map_code;

   assign test_req = !bist_en_n;

   bist_lfsr_gen #(.DATA_W(DATA_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_gen (
      .clk(clk), .rst_n(rst_n), .test_req(test_req), .src_sel(src_sel),
      .fifo_cmd(fifo_cmd), .fifo_data(fifo_data),
      .byp_cmd(byp_cmd), .byp_data(byp_data), .ctl_code(ctl_code),
      .state(state), .mode_q(mode_q));

   bist_char_map #(.DATA_W(DATA_W), .NUM_SPECIAL(NUM_SPECIAL)) u_txmap (
      .state(state), .cmd(map_cmd), .code(map_code));

   assign tx_cmd      = mode_q ? map_cmd  : state[DATA_W];
   assign tx_data     = mode_q ? map_code : state[DATA_W-1:0];
   assign test_active = mode_q;
   assign seq_start   = mode_q && state == '1;

   if (CHECKER_EN) begin : g_chk
      bist_checker #(.DATA_W(DATA_W), .NUM_SPECIAL(NUM_SPECIAL), .ERR_W(ERR_W),
                     .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_chk (
         .clk(clk), .rst_n(rst_n), .test_req(test_req), .rx_valid(rx_valid),
         .rx_cmd(rx_cmd), .rx_data(rx_data),
         .err_count(err_count), .locked(chk_locked));
   end else begin : g_nochk
      assign err_count  = '0;
      assign chk_locked = 1'b0;
   end

   // R6
   cmd_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_active && tx_cmd) |-> tx_data <= VIOL);
   // R5
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> !seq_start);
   // R10
   leave_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bist_en_n |=> !test_active);
endmodule

// File: tb/sim_bist_pattern_engine.sv
module sim_bist_pattern_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bist_en_n = 1'b1;
   logic [1:0] src_sel = 2'd0;
   logic       fifo_cmd = 1'b0, byp_cmd = 1'b0, rx_valid = 1'b0, rx_cmd = 1'b0;
   logic [7:0] fifo_data = 8'h00, byp_data = 8'h00, ctl_code = 8'h00, rx_data = 8'h00;
   logic       tx_cmd, test_active, seq_start, chk_locked;
   logic [7:0] tx_data;
   logic [15:0] err_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bist_pattern_engine u0 (
      .clk(clk), .rst_n(rst_n), .bist_en_n(bist_en_n), .src_sel(src_sel),
      .fifo_cmd(fifo_cmd), .fifo_data(fifo_data), .byp_cmd(byp_cmd), .byp_data(byp_data),
      .ctl_code(ctl_code), .tx_cmd(tx_cmd), .tx_data(tx_data), .test_active(test_active),
      .seq_start(seq_start), .rx_valid(rx_valid), .rx_cmd(rx_cmd), .rx_data(rx_data),
      .err_count(err_count), .chk_locked(chk_locked));

   function automatic logic [8:0] mstep(input logic [8:0] s);
      return {s[7:0], s[8] ^ s[4]};
   endfunction

   function automatic logic [8:0] mmap(input logic [8:0] s);
      logic [7:0] p;
      p = s[7:0];
      if (s[8]) return {1'b0, p};
      if (p >= 8'd1 && p <= 8'd16) return {1'b1, p - 8'd1};
      return {1'b1, 8'd15};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [8:0] s;
      int starts;
      bit seen_d[256];
      bit seen_c[16];
      int nd, nc;

      // R1 reset state
      repeat (3) tick();
      chk("R1 reset", {tx_cmd, tx_data, test_active, seq_start, err_count, chk_locked}, '0);
      rst_n = 1'b1;
      tick();
      chk("R1 after reset", {tx_cmd, tx_data, test_active, seq_start, err_count, chk_locked}, '0);

      // R2 normal-mode source selection
      fifo_cmd = 1'b0; fifo_data = 8'h3C;
      byp_cmd = 1'b1;  byp_data = 8'hA5;
      ctl_code = 8'h5E;
      for (int k = 0; k < 4; k++) begin
         src_sel = 2'(k);
         tick();
         case (k)
            0: chk("R2 fifo", {tx_cmd, tx_data}, {1'b0, 8'h3C});
            1: chk("R2 bypass", {tx_cmd, tx_data}, {1'b1, 8'hA5});
            default: chk("R2 control", {tx_cmd, tx_data}, {1'b1, 8'h5E});
         endcase
         chk("R2 not test", test_active, 1'b0);
      end

      // R3 entry
      bist_en_n = 1'b0;
      tick();
      chk("R3 seed char", {tx_cmd, tx_data}, {1'b0, 8'hFF});
      chk("R3 flags", {test_active, seq_start}, 2'b11);

      // R4 R5 R6 R7 sweep over two periods
      s = 9'h1FF;
      starts = 0;
      for (int i = 0; i <= 1022; i++) begin
         chk("R6 char", {tx_cmd, tx_data}, mmap(s));
         chk("R5 start strobe", seq_start, (s == 9'h1FF));
         if (seq_start) starts++;
         if (i < 511) begin
            if (!tx_cmd) seen_d[tx_data] = 1'b1;
            else if (tx_data < 8'd16) seen_c[tx_data[3:0]] = 1'b1;
         end
         if (i == 510) chk("R4 period closes", mstep(s), 9'h1FF);
         tick();
         s = mstep(s);
      end
      chk("R5 start count", starts, 3);
      nd = 0; nc = 0;
      for (int j = 0; j < 256; j++) if (seen_d[j]) nd++;
      for (int j = 0; j < 16; j++) if (seen_c[j]) nc++;
      chk("R7 data coverage", nd, 256);
      chk("R7 command coverage", nc, 16);

      // R10 leave and re-enter
      bist_en_n = 1'b1; src_sel = 2'd1;
      tick();
      chk("R10 leave char", {tx_cmd, tx_data}, {1'b1, 8'hA5});
      chk("R10 leave flag", test_active, 1'b0);
      bist_en_n = 1'b0;
      tick();
      chk("R10 reseed", {tx_cmd, tx_data, seq_start}, {1'b0, 8'hFF, 1'b1});

      // R9 garbage before lock
      rx_valid = 1'b1; rx_cmd = 1'b1; rx_data = 8'h80;
      repeat (5) tick();
      chk("R9 no count before lock", err_count, 16'd0);
      chk("R9 unlocked", chk_locked, 1'b0);

      // R9 lock on start, correct stream
      s = 9'h1FF;
      for (int i = 0; i < 30; i++) begin
         {rx_cmd, rx_data} = mmap(s);
         tick();
         s = mstep(s);
      end
      chk("R9 locked", chk_locked, 1'b1);
      chk("R8 clean stream", err_count, 16'd0);

      // R8 three mismatches
      for (int i = 0; i < 3; i++) begin
         {rx_cmd, rx_data} = mmap(s) ^ 9'h100;
         tick();
         s = mstep(s);
      end
      chk("R8 three errors", err_count, 16'd3);

      // R9 realign mid-stream
      s = 9'h1FF;
      for (int i = 0; i < 20; i++) begin
         {rx_cmd, rx_data} = mmap(s);
         tick();
         s = mstep(s);
      end
      chk("R9 realign no errors", err_count, 16'd3);

      // R8 saturation
      for (int i = 0; i < 65540; i++) begin
         {rx_cmd, rx_data} = mmap(s) ^ 9'h100;
         tick();
         s = mstep(s);
      end
      chk("R8 saturated", err_count, 16'hFFFF);
      repeat (5) tick();
      chk("R8 stays saturated", err_count, 16'hFFFF);

      // R10 re-entry clears the checker
      rx_valid = 1'b0;
      bist_en_n = 1'b1;
      tick();
      chk("R10 unlock on leave", chk_locked, 1'b0);
      bist_en_n = 1'b0;
      tick();
      chk("R10 error cleared", err_count, 16'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule